// File: doc/BRIEF.md
# Flash access protection and security gate

This block decides, request by request, whether flash traffic reaches the flash memory controller. Two requesters compete for one forwarded command port. The on-chip processor issues byte reads and writes. A JTAG programming port issues reads, writes, a set-secure command, a whole-device erase and a debug-access request. The outcome of each request is registered. The forwarded command, or a one-cycle error pulse to the requester, appears in the cycle after the request.

The block keeps a write-protect mask for a main array of eight sectors, a mask for a secondary array of four sectors, and a security flag. All three are loaded from non-volatile inputs while reset is held. The processor sees them through two status registers. When the security flag is set, JTAG loses all access except the bulk erase. The erase is a handshake with the flash controller, and its completion clears the flag and every protect bit. A supply monitor input holds off every write and erase while the supply is below the lockout level.

Top module: `flash_guard`

## Requirements
- R1: While `rst_n` is low, the main mask, secondary mask and security flag load from `nv_main_prot`, `nv_aux_prot` and `nv_secure`. Directly after reset, the status registers show those values.
- R2: While `supply_ok` is low, every flash write and erase (processor or JTAG) is blocked with an error pulse. Reads are unaffected.
- R3: Register offset C0h reads and writes the main mask. Bit i set means main sector i is write-protected. Offsets other than C0h and C2h read 00h.
- R4: Register offset C2h holds the secondary mask in bits 3..0. Bits 6..4 read 0. Bit 7 reads the security flag. A processor write changes bits 3..0 only and never changes the security flag.
- R5: A write to a protected sector is not forwarded and raises the requester's error pulse. Secondary sector numbers 4..7 count as protected.
- R6: While secured, JTAG read (`jt_cmd`=0), write (1), set-secure (2) and debug (4) are refused with `jt_err`. `jt_dbg_grant` stays low and `jt_rdata` reads 00h. When unsecured, a granted JTAG read shows `fl_rdata` on `jt_rdata` in the cycle `fl_req` is high. Codes 5..7 are always refused.
- R7: A JTAG bulk erase (`jt_cmd`=3) is accepted whether or not the device is secured. It forwards one command with `fl_erase`=1 and sets `erase_busy`. The state is left unchanged until `fl_erase_done` arrives. At the edge where `fl_erase_done` is sampled, `erase_busy`, the security flag and both masks all clear.
- R8: A processor read is forwarded whenever no erase is in progress, secured or not.
- R9: The security flag is set only by a granted JTAG set-secure command, and only while unsecured.
- R10: A blocked request gives one error pulse per request cycle and nothing on the forwarded port. The error drops when requests stop.
- R11: If both requesters ask in the same cycle, the processor request is decided and the JTAG request is refused with `jt_err`.
- R12: While `erase_busy` is high, every flash request from either side is refused with an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, loads non-volatile state |
| supply_ok | input | 1 | Supply above lockout level |
| nv_main_prot | input | MAIN_SECTORS | Non-volatile main write-protect mask |
| nv_aux_prot | input | AUX_SECTORS | Non-volatile secondary write-protect mask |
| nv_secure | input | 1 | Non-volatile security flag |
| cpu_reg_wr | input | 1 | Processor status-register write strobe |
| cpu_reg_addr | input | 8 | Status-register offset |
| cpu_reg_wdata | input | 8 | Status-register write data |
| cpu_reg_rdata | output | 8 | Status-register read data (combinational) |
| cpu_req | input | 1 | Processor flash request |
| cpu_we | input | 1 | Processor request is a write |
| cpu_aux | input | 1 | Processor targets secondary array |
| cpu_sector | input | 3 | Processor sector number |
| cpu_wdata | input | 8 | Processor write data |
| cpu_err | output | 1 | Processor request refused |
| jt_req | input | 1 | JTAG request |
| jt_cmd | input | 3 | JTAG command code |
| jt_aux | input | 1 | JTAG targets secondary array |
| jt_sector | input | 3 | JTAG sector number |
| jt_wdata | input | 8 | JTAG write data |
| jt_rdata | output | 8 | JTAG read data, 00h when not granted |
| jt_err | output | 1 | JTAG request refused |
| jt_dbg_grant | output | 1 | Debug access granted pulse |
| fl_req | output | 1 | Forwarded command valid |
| fl_we | output | 1 | Forwarded command is a write |
| fl_erase | output | 1 | Forwarded command is a bulk erase |
| fl_aux | output | 1 | Forwarded array select |
| fl_sector | output | 3 | Forwarded sector number |
| fl_wdata | output | 8 | Forwarded write data |
| fl_from_jtag | output | 1 | Forwarded command came from JTAG |
| fl_rdata | input | 8 | Read data from flash controller |
| fl_erase_done | input | 1 | Bulk erase finished |
| erase_busy | output | 1 | Bulk erase in progress |

## Verification
The assertions take for granted that `fl_erase_done` arrives only while `erase_busy` is high. They also take the non-volatile inputs as stable while reset is held. The stimulus raises the done strobe only after it has seen `erase_busy` at a port, and it changes the non-volatile values only inside reset pulses. Requests are held for exactly one cycle and applied away from the clock edge. This keeps every registered decision tied to one clear request cycle.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

   localparam int FG_DATA_W = 8;
   localparam int FG_SEC_W  = 3;

   typedef enum logic [2:0] {
      JT_READ   = 3'd0,
      JT_WRITE  = 3'd1,
      JT_SETSEC = 3'd2,
      JT_ERASE  = 3'd3,
      JT_DEBUG  = 3'd4
   } jt_cmd_e;

   typedef struct packed {
      logic                 req;
      logic                 we;
      logic                 erase;
      logic                 aux;
      logic [FG_SEC_W-1:0]  sector;
      logic [FG_DATA_W-1:0] wdata;
      logic                 from_jtag;
   } fl_cmd_t;

endpackage

// File: rtl/fg_prot_regs.sv
module fg_prot_regs
   import flash_guard_pkg::*;
#(
   parameter int             MAIN_SECTORS = 8,
   parameter int             AUX_SECTORS  = 4,
   parameter logic [7:0]     MAIN_OFS     = 8'hC0,
   parameter logic [7:0]     AUX_OFS      = 8'hC2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [MAIN_SECTORS-1:0] nv_main,
   input  logic [AUX_SECTORS-1:0]  nv_aux,
   input  logic                    nv_secure,
   input  logic                    wr,
   input  logic [7:0]              addr,
   input  logic [7:0]              wdata,
   input  logic                    set_secure,
   input  logic                    clear_all,
   output logic [7:0]              rdata,
   output logic [7:0]              main_pad,
   output logic [7:0]              aux_pad,
   output logic                    secure
);

   localparam int PAD_W = 8;

   logic [MAIN_SECTORS-1:0] main_q;
   logic [AUX_SECTORS-1:0]  aux_q;
   logic                    secure_q;
   logic [PAD_W-1:0]        main_view;
   logic [PAD_W-1:0]        aux_view;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         main_q   <= nv_main;
         aux_q    <= nv_aux;
         secure_q <= nv_secure;
      end else if (clear_all) begin
         main_q   <= '0;
         aux_q    <= '0;
         secure_q <= 1'b0;
      end else begin
         if (wr && addr == MAIN_OFS) main_q <= wdata[MAIN_SECTORS-1:0];
         if (wr && addr == AUX_OFS)  aux_q  <= wdata[AUX_SECTORS-1:0];
         if (set_secure)             secure_q <= 1'b1;
      end
   end

   // Sectors beyond the configured count read as 0 but gate as protected.
   for (genvar i = 0; i < PAD_W; i++) begin : g_main_bit
      if (i < MAIN_SECTORS) begin : g_live
         assign main_view[i] = main_q[i];
         assign main_pad[i]  = main_q[i];
      end else begin : g_absent
         assign main_view[i] = 1'b0;
         assign main_pad[i]  = 1'b1;
      end
   end

   for (genvar i = 0; i < PAD_W; i++) begin : g_aux_bit
      if (i < AUX_SECTORS) begin : g_live
         assign aux_view[i] = aux_q[i];
         assign aux_pad[i]  = aux_q[i];
      end else begin : g_absent
         assign aux_view[i] = 1'b0;
         assign aux_pad[i]  = 1'b1;
      end
   end

   always_comb begin
      if (addr == MAIN_OFS)
         rdata = main_view;
      else if (addr == AUX_OFS)
         rdata = {secure_q, 3'b000, aux_view[3:0]};
      else
         rdata = 8'h00;
   end

   assign secure = secure_q;

endmodule

// File: rtl/fg_erase_ctl.sv
module fg_erase_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic done,
   output logic busy,
   output logic clear_all
);

   logic busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         busy_q <= 1'b0;
      else if (busy_q && done)
         busy_q <= 1'b0;
      else if (start)
         busy_q <= 1'b1;
   end

   assign busy      = busy_q;
   assign clear_all = busy_q && done;

endmodule

// File: rtl/fg_policy.sv
module fg_policy
   import flash_guard_pkg::*;
(
   input  logic                 supply_ok,
   input  logic                 busy,
   input  logic                 secure,
   input  logic [7:0]           main_pad,
   input  logic [7:0]           aux_pad,
   input  logic                 cpu_req,
   input  logic                 cpu_we,
   input  logic                 cpu_aux,
   input  logic [FG_SEC_W-1:0]  cpu_sector,
   input  logic [FG_DATA_W-1:0] cpu_wdata,
   input  logic                 jt_req,
   input  logic [2:0]           jt_cmd,
   input  logic                 jt_aux,
   input  logic [FG_SEC_W-1:0]  jt_sector,
   input  logic [FG_DATA_W-1:0] jt_wdata,
   output fl_cmd_t              nxt,
   output logic                 cpu_bad,
   output logic                 jt_bad,
   output logic                 jt_rd_ok,
   output logic                 jt_set_ok,
   output logic                 jt_erase_ok,
   output logic                 jt_dbg_ok
);

   logic prot_cpu, prot_jt;
   logic cpu_ok, jt_go, jt_wr_ok, jt_ok;

   always_comb begin
      prot_cpu = cpu_aux ? aux_pad[cpu_sector] : main_pad[cpu_sector];
      prot_jt  = jt_aux  ? aux_pad[jt_sector]  : main_pad[jt_sector];

      cpu_ok  = cpu_req && !busy && (!cpu_we || (supply_ok && !prot_cpu));
      cpu_bad = cpu_req && !cpu_ok;

      jt_go       = jt_req && !cpu_req && !busy;
      jt_rd_ok    = 1'b0;
      jt_wr_ok    = 1'b0;
      jt_set_ok   = 1'b0;
      jt_erase_ok = 1'b0;
      jt_dbg_ok   = 1'b0;
      case (jt_cmd)
         JT_READ:   jt_rd_ok    = jt_go && !secure;
         JT_WRITE:  jt_wr_ok    = jt_go && !secure && supply_ok && !prot_jt;
         JT_SETSEC: jt_set_ok   = jt_go && !secure;
         JT_ERASE:  jt_erase_ok = jt_go && supply_ok;
         JT_DEBUG:  jt_dbg_ok   = jt_go && !secure;
         default:   ;
      endcase
      jt_ok  = jt_rd_ok || jt_wr_ok || jt_set_ok || jt_erase_ok || jt_dbg_ok;
      jt_bad = jt_req && !jt_ok;

      nxt = '0;
      if (cpu_ok) begin
         nxt.req    = 1'b1;
         nxt.we     = cpu_we;
         nxt.aux    = cpu_aux;
         nxt.sector = cpu_sector;
         nxt.wdata  = cpu_wdata;
      end else if (jt_rd_ok || jt_wr_ok || jt_erase_ok) begin
         nxt.req       = 1'b1;
         nxt.we        = jt_wr_ok;
         nxt.erase     = jt_erase_ok;
         nxt.aux       = jt_aux;
         nxt.sector    = jt_sector;
         nxt.wdata     = jt_wdata;
         nxt.from_jtag = 1'b1;
      end
   end

endmodule

// File: rtl/flash_guard.sv
module flash_guard
   import flash_guard_pkg::*;
#(
   parameter int         MAIN_SECTORS = 8,
   parameter int         AUX_SECTORS  = 4,
   parameter logic [7:0] MAIN_OFS     = 8'hC0,
   parameter logic [7:0] AUX_OFS      = 8'hC2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    supply_ok,
   input  logic [MAIN_SECTORS-1:0] nv_main_prot,
   input  logic [AUX_SECTORS-1:0]  nv_aux_prot,
   input  logic                    nv_secure,
   input  logic                    cpu_reg_wr,
   input  logic [7:0]              cpu_reg_addr,
   input  logic [7:0]              cpu_reg_wdata,
   output logic [7:0]              cpu_reg_rdata,
   input  logic                    cpu_req,
   input  logic                    cpu_we,
   input  logic                    cpu_aux,
   input  logic [2:0]              cpu_sector,
   input  logic [7:0]              cpu_wdata,
   output logic                    cpu_err,
   input  logic                    jt_req,
   input  logic [2:0]              jt_cmd,
   input  logic                    jt_aux,
   input  logic [2:0]              jt_sector,
   input  logic [7:0]              jt_wdata,
   output logic [7:0]              jt_rdata,
   output logic                    jt_err,
   output logic                    jt_dbg_grant,
   output logic                    fl_req,
   output logic                    fl_we,
   output logic                    fl_erase,
   output logic                    fl_aux,
   output logic [2:0]              fl_sector,
   output logic [7:0]              fl_wdata,
   output logic                    fl_from_jtag,
   input  logic [7:0]              fl_rdata,
   input  logic                    fl_erase_done,
   output logic                    erase_busy
);

   if (MAIN_SECTORS < 1 || MAIN_SECTORS > 8) begin : g_bad_main
      $error("flash_guard: MAIN_SECTORS must be 1..8");
   end
   if (AUX_SECTORS < 1 || AUX_SECTORS > 4) begin : g_bad_aux
      $error("flash_guard: AUX_SECTORS must be 1..4");
   end
   if (MAIN_OFS == AUX_OFS) begin : g_bad_ofs
      $error("flash_guard: register offsets must differ");
   end

   logic [7:0] main_pad, aux_pad;
   logic       secure;
   logic       clear_all;
   fl_cmd_t    nxt, cmd_q;
   logic       cpu_bad, jt_bad, jt_rd_ok, jt_set_ok, jt_erase_ok, jt_dbg_ok;
   logic       cpu_err_q, jt_err_q, dbg_q, rd_ok_q;

   fg_prot_regs #(
      .MAIN_SECTORS(MAIN_SECTORS),
      .AUX_SECTORS (AUX_SECTORS),
      .MAIN_OFS    (MAIN_OFS),
      .AUX_OFS     (AUX_OFS)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .nv_main   (nv_main_prot),
      .nv_aux    (nv_aux_prot),
      .nv_secure (nv_secure),
      .wr        (cpu_reg_wr),
      .addr      (cpu_reg_addr),
      .wdata     (cpu_reg_wdata),
      .set_secure(jt_set_ok),
      .clear_all (clear_all),
      .rdata     (cpu_reg_rdata),
      .main_pad  (main_pad),
      .aux_pad   (aux_pad),
      .secure    (secure)
   );

   fg_erase_ctl u_erase (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (jt_erase_ok),
      .done     (fl_erase_done),
      .busy     (erase_busy),
      .clear_all(clear_all)
   );

   fg_policy u_policy (
      .supply_ok  (supply_ok),
      .busy       (erase_busy),
      .secure     (secure),
      .main_pad   (main_pad),
      .aux_pad    (aux_pad),
      .cpu_req    (cpu_req),
      .cpu_we     (cpu_we),
      .cpu_aux    (cpu_aux),
      .cpu_sector (cpu_sector),
      .cpu_wdata  (cpu_wdata),
      .jt_req     (jt_req),
      .jt_cmd     (jt_cmd),
      .jt_aux     (jt_aux),
      .jt_sector  (jt_sector),
      .jt_wdata   (jt_wdata),
      .nxt        (nxt),
      .cpu_bad    (cpu_bad),
      .jt_bad     (jt_bad),
      .jt_rd_ok   (jt_rd_ok),
      .jt_set_ok  (jt_set_ok),
      .jt_erase_ok(jt_erase_ok),
      .jt_dbg_ok  (jt_dbg_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q     <= '0;
         cpu_err_q <= 1'b0;
         jt_err_q  <= 1'b0;
         dbg_q     <= 1'b0;
         rd_ok_q   <= 1'b0;
      end else begin
         cmd_q     <= nxt;
         cpu_err_q <= cpu_bad;
         jt_err_q  <= jt_bad;
         dbg_q     <= jt_dbg_ok;
         rd_ok_q   <= jt_rd_ok;
      end
   end

   assign fl_req       = cmd_q.req;
   assign fl_we        = cmd_q.we;
   assign fl_erase     = cmd_q.erase;
   assign fl_aux       = cmd_q.aux;
   assign fl_sector    = cmd_q.sector;
   assign fl_wdata     = cmd_q.wdata;
   assign fl_from_jtag = cmd_q.from_jtag;
   assign cpu_err      = cpu_err_q;
   assign jt_err       = jt_err_q;
   assign jt_dbg_grant = dbg_q;
   assign jt_rdata     = rd_ok_q ? fl_rdata : 8'h00;

endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       supply_ok,
   input logic       cpu_req,
   input logic       cpu_we,
   input logic       cpu_reg_wr,
   input logic       cpu_err,
   input logic       jt_req,
   input logic [2:0] jt_cmd,
   input logic [7:0] jt_rdata,
   input logic       jt_err,
   input logic       jt_dbg_grant,
   input logic       fl_req,
   input logic       fl_we,
   input logic       fl_erase,
   input logic       fl_aux,
   input logic [2:0] fl_sector,
   input logic       fl_from_jtag,
   input logic       fl_erase_done,
   input logic       erase_busy,
   input logic       secure,
   input logic [7:0] main_pad,
   input logic [7:0] aux_pad
);

   p_supply_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req && (fl_we || fl_erase) |-> $past(supply_ok));

   p_main_prot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req && fl_we && !fl_aux |-> ((($past(main_pad) >> fl_sector) & 8'h01) == 8'h00));

   p_aux_prot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req && fl_we && fl_aux |-> ((($past(aux_pad) >> fl_sector) & 8'h01) == 8'h00));

   p_cpu_no_secure_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_reg_wr && !jt_req && !(erase_busy && fl_erase_done) |=> $stable(secure));

   p_jtag_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req && fl_from_jtag && !fl_erase |-> !$past(secure));

   p_debug_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      jt_dbg_grant |-> !$past(secure));

   p_blank_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      jt_err |-> jt_rdata == 8'h00);

   p_erase_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      erase_busy && fl_erase_done |=> !secure && !erase_busy);

   p_cpu_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && !cpu_we && !erase_busy |=> fl_req && !fl_from_jtag && !cpu_err);

   p_secure_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(secure) |-> $past(jt_req && !cpu_req && jt_cmd == 3'd2));

   p_err_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_err |-> !(fl_req && !fl_from_jtag));

   p_collide_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && jt_req |=> jt_err);

   p_busy_block_r12: assert property (@(posedge clk) disable iff (!rst_n)
      erase_busy |=> !fl_req);

endmodule

bind flash_guard flash_guard_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .supply_ok    (supply_ok),
   .cpu_req      (cpu_req),
   .cpu_we       (cpu_we),
   .cpu_reg_wr   (cpu_reg_wr),
   .cpu_err      (cpu_err),
   .jt_req       (jt_req),
   .jt_cmd       (jt_cmd),
   .jt_rdata     (jt_rdata),
   .jt_err       (jt_err),
   .jt_dbg_grant (jt_dbg_grant),
   .fl_req       (fl_req),
   .fl_we        (fl_we),
   .fl_erase     (fl_erase),
   .fl_aux       (fl_aux),
   .fl_sector    (fl_sector),
   .fl_from_jtag (fl_from_jtag),
   .fl_erase_done(fl_erase_done),
   .erase_busy   (erase_busy),
   .secure       (secure),
   .main_pad     (main_pad),
   .aux_pad      (aux_pad)
);

// File: tb/flash_guard_tb_top.sv
module flash_guard_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       supply_ok = 1'b1;
   logic [7:0] nv_main_prot = 8'h00;
   logic [3:0] nv_aux_prot = 4'h0;
   logic       nv_secure = 1'b0;
   logic       cpu_reg_wr = 1'b0;
   logic [7:0] cpu_reg_addr = 8'h00;
   logic [7:0] cpu_reg_wdata = 8'h00;
   logic [7:0] cpu_reg_rdata;
   logic       cpu_req = 1'b0, cpu_we = 1'b0, cpu_aux = 1'b0;
   logic [2:0] cpu_sector = 3'd0;
   logic [7:0] cpu_wdata = 8'h00;
   logic       cpu_err;
   logic       jt_req = 1'b0;
   logic [2:0] jt_cmd = 3'd0;
   logic       jt_aux = 1'b0;
   logic [2:0] jt_sector = 3'd0;
   logic [7:0] jt_wdata = 8'h00;
   logic [7:0] jt_rdata;
   logic       jt_err, jt_dbg_grant;
   logic       fl_req, fl_we, fl_erase, fl_aux, fl_from_jtag;
   logic [2:0] fl_sector;
   logic [7:0] fl_wdata, fl_rdata;
   logic       fl_erase_done = 1'b0;
   logic       erase_busy;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   // flash controller model: read data derived from the target
   assign fl_rdata = {fl_aux, fl_sector, 4'hC};

   flash_guard dut_i (.*);

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic do_reset(input logic [7:0] m, input logic [3:0] a, input logic s);
      rst_n = 1'b0; nv_main_prot = m; nv_aux_prot = a; nv_secure = s;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic reg_wr(input logic [7:0] addr, input logic [7:0] data);
      cpu_reg_wr = 1'b1; cpu_reg_addr = addr; cpu_reg_wdata = data;
      @(negedge clk);
      cpu_reg_wr = 1'b0;
   endtask

   task automatic reg_rd(input logic [7:0] addr, output logic [7:0] data);
      cpu_reg_addr = addr;
      #1 data = cpu_reg_rdata;
   endtask

   task automatic cpu_op(input logic we, input logic aux, input logic [2:0] sec);
      cpu_req = 1'b1; cpu_we = we; cpu_aux = aux; cpu_sector = sec; cpu_wdata = 8'h3C;
      @(negedge clk);
      cpu_req = 1'b0;
   endtask

   task automatic jt_op(input logic [2:0] cmd, input logic aux, input logic [2:0] sec);
      jt_req = 1'b1; jt_cmd = cmd; jt_aux = aux; jt_sector = sec; jt_wdata = 8'h96;
      @(negedge clk);
      jt_req = 1'b0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++; n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin : stim
      logic [7:0] rd;
      @(negedge clk);

      // R1: reset load
      do_reset(8'h5A, 4'h9, 1'b1);
      reg_rd(8'hC0, rd); check("R1 main after reset", rd, 8'h5A);
      reg_rd(8'hC2, rd); check("R1 aux after reset", rd, 8'h89);
      check("R1 busy after reset", erase_busy, 0);
      check("R1 fl_req after reset", fl_req, 0);

      do_reset(8'h00, 4'h0, 1'b0);
      // R3: other offsets read zero
      reg_rd(8'hC1, rd); check("R3 unmapped offset", rd, 0);

      // R3 / R5: main mask sweep, processor and JTAG writes
      for (int m = 0; m < 256; m++) begin
         reg_wr(8'hC0, m[7:0]);
         reg_rd(8'hC0, rd); check("R3 main readback", rd, m);
         for (int s = 0; s < 8; s++) begin
            cpu_op(1'b1, 1'b0, s[2:0]);
            check("R5 cpu main fwd", {fl_req, fl_we, fl_from_jtag}, m[s] ? 3'b000 : 3'b110);
            check("R5 cpu main err", cpu_err, m[s]);
            if (m % 37 == 0) begin
               jt_op(3'd1, 1'b0, s[2:0]);
               check("R5 jtag main fwd", {fl_req, fl_from_jtag}, m[s] ? 2'b00 : 2'b11);
               check("R5 jtag main err", jt_err, m[s]);
            end
         end
      end
      reg_wr(8'hC0, 8'h00);

      // R4 / R5: secondary mask sweep, sectors 4..7 always protected
      for (int m = 0; m < 16; m++) begin
         reg_wr(8'hC2, {4'hF, m[3:0]});
         reg_rd(8'hC2, rd); check("R4 aux readback, bit7 and 6..4 zero", rd, m);
         for (int s = 0; s < 8; s++) begin
            cpu_op(1'b1, 1'b1, s[2:0]);
            check("R5 cpu aux err", cpu_err, (s >= 4) || m[s]);
            check("R5 cpu aux fwd", fl_req, !((s >= 4) || m[s]));
         end
      end
      reg_wr(8'hC2, 8'h00);

      // R10: error gone once requests stop
      reg_wr(8'hC0, 8'h01);
      cpu_op(1'b1, 1'b0, 3'd0);
      check("R10 err pulse", cpu_err, 1);
      @(negedge clk);
      check("R10 err drops", {cpu_err, fl_req}, 0);
      reg_wr(8'hC0, 8'h00);

      // R2: supply lockout
      supply_ok = 1'b0;
      cpu_op(1'b1, 1'b0, 3'd2);
      check("R2 cpu write locked", {fl_req, cpu_err}, 2'b01);
      cpu_op(1'b0, 1'b0, 3'd2);
      check("R2 cpu read allowed", {fl_req, cpu_err}, 2'b10);
      jt_op(3'd1, 1'b0, 3'd2);
      check("R2 jtag write locked", {fl_req, jt_err}, 2'b01);
      jt_op(3'd3, 1'b0, 3'd0);
      check("R2 erase locked", {fl_req, jt_err, erase_busy}, 3'b010);
      supply_ok = 1'b1;
      cpu_op(1'b1, 1'b0, 3'd2);
      check("R2 write after recovery", {fl_req, fl_wdata}, {1'b1, 8'h3C});

      // R6: unsecured JTAG read / debug work
      jt_op(3'd0, 1'b1, 3'd3);
      check("R6 jtag read unsecured", {fl_req, fl_from_jtag, jt_rdata}, {2'b11, 1'b1, 3'd3, 4'hC});
      jt_op(3'd4, 1'b0, 3'd0);
      check("R6 debug unsecured", {jt_dbg_grant, jt_err}, 2'b10);
      jt_op(3'd6, 1'b0, 3'd0);
      check("R6 unknown code refused", {jt_err, fl_req}, 2'b10);

      // R9: set secure via JTAG
      jt_op(3'd2, 1'b0, 3'd0);
      reg_rd(8'hC2, rd); check("R9 secure set", rd[7], 1);
      jt_op(3'd2, 1'b0, 3'd0);
      check("R9 set while secured refused", jt_err, 1);

      // R4: processor cannot clear security
      reg_wr(8'hC2, 8'h03);
      reg_rd(8'hC2, rd); check("R4 bit7 write ignored", rd, 8'h83);

      // R6: secured JTAG
      jt_op(3'd0, 1'b0, 3'd1);
      check("R6 secured read", {fl_req, jt_err, jt_rdata}, {2'b01, 8'h00});
      jt_op(3'd1, 1'b0, 3'd5);
      check("R6 secured write", {fl_req, jt_err}, 2'b01);
      jt_op(3'd4, 1'b0, 3'd0);
      check("R6 secured debug", {jt_dbg_grant, jt_err}, 2'b01);

      // R8: processor read while secured
      cpu_op(1'b0, 1'b0, 3'd6);
      check("R8 cpu read secured", {fl_req, fl_from_jtag, cpu_err, fl_sector}, {3'b100, 3'd6});

      // R11: collision
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_sector = 3'd1;
      jt_op(3'd3, 1'b0, 3'd0);
      cpu_req = 1'b0;
      check("R11 cpu wins", {fl_req, fl_from_jtag, jt_err, erase_busy}, 4'b1010);

      // R7: bulk erase while secured
      reg_wr(8'hC0, 8'hA5);
      jt_op(3'd3, 1'b0, 3'd0);
      check("R7 erase forwarded", {fl_req, fl_erase, fl_from_jtag, erase_busy}, 4'b1111);
      @(negedge clk); @(negedge clk);
      check("R7 busy held", erase_busy, 1);
      reg_rd(8'hC0, rd); check("R7 main kept while busy", rd, 8'hA5);
      // R12: requests refused during erase
      cpu_op(1'b0, 1'b0, 3'd0);
      check("R12 cpu read busy", {fl_req, cpu_err}, 2'b01);
      jt_op(3'd3, 1'b0, 3'd0);
      check("R12 jtag busy", {fl_req, jt_err}, 2'b01);
      fl_erase_done = 1'b1;
      @(negedge clk);
      fl_erase_done = 1'b0;
      check("R7 busy cleared", erase_busy, 0);
      reg_rd(8'hC0, rd); check("R7 main cleared", rd, 0);
      reg_rd(8'hC2, rd); check("R7 aux and security cleared", rd, 0);
      jt_op(3'd0, 1'b0, 3'd2);
      check("R7 jtag read after erase", {fl_req, jt_err, jt_rdata}, {2'b10, 1'b0, 3'd2, 4'hC});

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule